// File: doc/BRIEF.md
# Sparse Ternary Challenge Sampler

This block turns a stream of pseudo-random 32-bit words, taken from an extendable-output hash, into a sparse ternary polynomial of 256 coefficients. Exactly `TAU` coefficients are +1 or −1 and every other coefficient is zero. The first eight bytes of the stream supply the signs. Each byte after those is a candidate position. A candidate is accepted or thrown away by comparing it with a running threshold, and accepted positions are mixed by an in-place shuffle. After the last placement, the block writes all 256 coefficients to a coefficient memory in ascending address order. Each coefficient is written as a residue in [0, Q), so −1 is stored as Q − 1.

No 256-entry scratch array is used. The block keeps a shift register of variable depth that holds (offset, sign) pairs. For each accepted position j, the register is rotated once through its live entries. Any stored offset equal to j is rewritten to the current threshold and keeps its sign. The pair (j, new sign) is then appended. During the write pass, each address is looked up in parallel against the live entries.

A controller pulses `start` after the hash has been seeded. It then feeds words through the valid/ready input and waits for `done`.

Top module: `challenge_sampler`

## Requirements
- R1: After reset, `done`, `mem_we` and `word_ready` are all low.
- R2: Each accepted input word is split into four bytes, least significant byte first. The first eight bytes after `start` form a 64-bit sign word, with byte 0 in bits 7:0. Bit k of this word is the sign of the k-th placement, where 1 means −1 and 0 means +1.
- R3: The threshold i starts at 256 − TAU and rises by one after each placement, up to 255. A candidate byte greater than i is discarded and has no effect on the result.
- R4: When candidate j ≤ i is accepted, the coefficient held at position j moves to position i, and position j receives ±1 from the next sign bit. When j equals i, only position i is set.
- R5: After the last placement, the block writes 256 coefficients on consecutive cycles. Addresses run 0 to 255 in order. Each value is 0, 1 or Q − 1.
- R6: `done` pulses high for one cycle, in the cycle after the write to address 255. Exactly TAU written coefficients are nonzero.
- R7: `word_ready` is low whenever the block is not taking stream bytes, including while idle. Bytes left over from the last word of a run are discarded at the next `start`. A `start` pulse while a run is in progress is ignored.
- R8: A candidate index that repeats one already placed, even many times in a row, is handled by the swap rule of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a sampling run when idle |
| done | output | 1 | One-cycle pulse after the final memory write |
| word_valid | input | 1 | Hash output word is present |
| word_ready | output | 1 | Block accepts the word this cycle |
| word_data | input | WORD_W | Hash output word |
| mem_we | output | 1 | Coefficient write strobe |
| mem_addr | output | 8 | Coefficient index |
| mem_data | output | COEF_W | Coefficient value in [0, Q) |

## Verification
The coefficient writes come out of registered state. Each write is visible in the cycle after the clock edge that set the address, and `done` follows one cycle after the write to address 255. The bench samples every output on the falling edge. It records the cycle of each write and requires `done` in exactly the next sampled cycle. A stream word counts as consumed only when `word_ready` was high at the preceding falling edge. Stream consumption therefore never depends on the order of events at a rising edge. Expected coefficients come from a direct array-based model of the shuffle, and they are compared after the write pass.

// File: rtl/csamp_pkg.sv
package csamp_pkg;

    localparam int SAMP_W = 8;
    localparam int NCOEF  = 256;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SIGNS,
        ST_FETCH,
        ST_ROTATE,
        ST_PUSH,
        ST_WRITE
    } csamp_state_e;

    // one placed nonzero coefficient: position and sign (1 = negative)
    typedef struct packed {
        logic [SAMP_W-1:0] ofs;
        logic              neg;
    } pos_entry_t;

endpackage

// File: rtl/csamp_byte_unpack.sv
module csamp_byte_unpack #(
    parameter int WORD_W = 32,
    parameter int SAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [WORD_W-1:0] word_data,
    output logic              samp_valid,
    output logic [SAMP_W-1:0] samp_data,
    input  logic              samp_take
);
    localparam int LANES = WORD_W / SAMP_W;
    localparam int CNT_W = $clog2(LANES + 1);

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [CNT_W-1:0]  cnt;
    } unpack_t;

    unpack_t st_d, st_q;

    assign word_ready = en && (st_q.cnt == '0);
    assign samp_valid = (st_q.cnt != '0);
    assign samp_data  = st_q.data[SAMP_W-1:0];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (word_valid && word_ready) begin
            st_d.data = word_data;
            st_d.cnt  = CNT_W'(LANES);
        end else if (samp_take && samp_valid) begin
            st_d.data = st_q.data >> SAMP_W;
            st_d.cnt  = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the lowest byte of an accepted word is offered first
    assert_low_byte_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready && !clr) |=> (samp_valid && samp_data == $past(word_data[SAMP_W-1:0])));

endmodule

// File: rtl/csamp_pos_shift.sv
module csamp_pos_shift
    import csamp_pkg::*;
#(
    parameter int TAU   = 39,
    parameter int DEP_W = $clog2(TAU + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     rot,
    input  logic                     push,
    input  logic [SAMP_W-1:0]        cmp_ofs,
    input  logic [SAMP_W-1:0]        repl_ofs,
    input  logic                     push_neg,
    output pos_entry_t [TAU-1:0]     ent,
    output logic [DEP_W-1:0]         depth
);
    typedef struct packed {
        pos_entry_t [TAU-1:0] ent;
        logic [DEP_W-1:0]     depth;
    } shift_t;

    shift_t     st_d, st_q;
    pos_entry_t head;

    assign ent   = st_q.ent;
    assign depth = st_q.depth;

    always_comb begin
        st_d = st_q;
        head = st_q.ent[0];
        if (head.ofs == cmp_ofs) head.ofs = repl_ofs;
        if (clr) begin
            st_d.depth = '0;
        end else if (rot) begin
            for (int k = 0; k < TAU; k++) begin
                if (k + 1 < int'(st_q.depth))       st_d.ent[k] = st_q.ent[k+1];
                else if (k + 1 == int'(st_q.depth)) st_d.ent[k] = head;
            end
        end else if (push) begin
            for (int k = 0; k < TAU; k++) begin
                if (k == int'(st_q.depth)) st_d.ent[k] = '{ofs: cmp_ofs, neg: push_neg};
            end
            st_d.depth = st_q.depth + DEP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |-> (st_q.depth < DEP_W'(TAU)));

    assert_rotate_keeps_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rot && !clr) |=> (st_q.depth == $past(st_q.depth)));

    assert_rotate_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rot |-> (st_q.depth != '0));

endmodule

// File: rtl/csamp_coef_lookup.sv
module csamp_coef_lookup
    import csamp_pkg::*;
#(
    parameter int          TAU    = 39,
    parameter int          DEP_W  = $clog2(TAU + 1),
    parameter int          COEF_W = 23,
    parameter logic [COEF_W-1:0] Q = 23'd8380417
) (
    input  pos_entry_t [TAU-1:0] ent,
    input  logic [DEP_W-1:0]     depth,
    input  logic [SAMP_W-1:0]    addr,
    output logic [TAU-1:0]       match,
    output logic [COEF_W-1:0]    coef
);
    logic [TAU-1:0] neg_vec;

    for (genvar k = 0; k < TAU; k++) begin : g_cmp
        assign match[k]   = (DEP_W'(k) < depth) && (ent[k].ofs == addr);
        assign neg_vec[k] = ent[k].neg;
    end

    always_comb begin
        if (match == '0)            coef = '0;
        else if (|(match & neg_vec)) coef = Q - COEF_W'(1);
        else                        coef = COEF_W'(1);
    end

endmodule

// File: rtl/challenge_sampler.sv
module challenge_sampler
    import csamp_pkg::*;
#(
    parameter int          TAU    = 39,
    parameter int          WORD_W = 32,
    parameter int          COEF_W = 23,
    parameter logic [COEF_W-1:0] Q = 23'd8380417
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [WORD_W-1:0] word_data,
    output logic              mem_we,
    output logic [7:0]        mem_addr,
    output logic [COEF_W-1:0] mem_data
);
    localparam int DEP_W   = $clog2(TAU + 1);
    localparam int SIGN_W  = 64;
    localparam int SBYTES  = SIGN_W / SAMP_W;
    localparam int SCNT_W  = $clog2(SBYTES);
    localparam logic [SAMP_W-1:0] THR0 = SAMP_W'(NCOEF - TAU);
    localparam logic [SAMP_W-1:0] THR_LAST = SAMP_W'(NCOEF - 1);

    typedef struct packed {
        csamp_state_e       st;
        logic [SAMP_W-1:0]  thr;
        logic [SAMP_W-1:0]  j;
        logic [SIGN_W-1:0]  signs;
        logic [SCNT_W-1:0]  scnt;
        logic [DEP_W-1:0]   rcnt;
        logic [7:0]         addr;
        logic               done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 clr, en, take, rot, push;
    logic                 samp_valid;
    logic [SAMP_W-1:0]    samp_data;
    pos_entry_t [TAU-1:0] ent;
    logic [DEP_W-1:0]     depth;
    logic [TAU-1:0]       match;

    csamp_byte_unpack #(.WORD_W(WORD_W), .SAMP_W(SAMP_W)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .en         (en),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .word_data  (word_data),
        .samp_valid (samp_valid),
        .samp_data  (samp_data),
        .samp_take  (take)
    );

    csamp_pos_shift #(.TAU(TAU), .DEP_W(DEP_W)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .rot      (rot),
        .push     (push),
        .cmp_ofs  (ctl_q.j),
        .repl_ofs (ctl_q.thr),
        .push_neg (ctl_q.signs[0]),
        .ent      (ent),
        .depth    (depth)
    );

    csamp_coef_lookup #(.TAU(TAU), .DEP_W(DEP_W), .COEF_W(COEF_W), .Q(Q)) u_look (
        .ent   (ent),
        .depth (depth),
        .addr  (ctl_q.addr),
        .match (match),
        .coef  (mem_data)
    );

    assign en       = (ctl_q.st == ST_SIGNS) || (ctl_q.st == ST_FETCH);
    assign mem_we   = (ctl_q.st == ST_WRITE);
    assign mem_addr = ctl_q.addr;
    assign done     = ctl_q.done;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        clr  = 1'b0;
        take = 1'b0;
        rot  = 1'b0;
        push = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    clr        = 1'b1;
                    ctl_d.st   = ST_SIGNS;
                    ctl_d.scnt = '0;
                end
            end
            ST_SIGNS: begin
                if (samp_valid) begin
                    take        = 1'b1;
                    ctl_d.signs = {samp_data, ctl_q.signs[SIGN_W-1:SAMP_W]};
                    ctl_d.scnt  = ctl_q.scnt + SCNT_W'(1);
                    if (ctl_q.scnt == SCNT_W'(SBYTES - 1)) begin
                        ctl_d.st  = ST_FETCH;
                        ctl_d.thr = THR0;
                    end
                end
            end
            ST_FETCH: begin
                if (samp_valid) begin
                    take = 1'b1;
                    if (samp_data <= ctl_q.thr) begin
                        ctl_d.j    = samp_data;
                        ctl_d.rcnt = '0;
                        ctl_d.st   = (depth == '0) ? ST_PUSH : ST_ROTATE;
                    end
                end
            end
            ST_ROTATE: begin
                rot        = 1'b1;
                ctl_d.rcnt = ctl_q.rcnt + DEP_W'(1);
                if (ctl_q.rcnt == depth - DEP_W'(1)) ctl_d.st = ST_PUSH;
            end
            ST_PUSH: begin
                push        = 1'b1;
                ctl_d.signs = ctl_q.signs >> 1;
                if (ctl_q.thr == THR_LAST) begin
                    ctl_d.st   = ST_WRITE;
                    ctl_d.addr = '0;
                end else begin
                    ctl_d.thr = ctl_q.thr + SAMP_W'(1);
                    ctl_d.st  = ST_FETCH;
                end
            end
            ST_WRITE: begin
                ctl_d.addr = ctl_q.addr + 8'd1;
                if (ctl_q.addr == 8'hFF) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assert_write_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 8'd1));

    assert_coef_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_data == '0 || mem_data == COEF_W'(1) || mem_data == Q - COEF_W'(1)));

    assert_unique_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $onehot0(match));

    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_we) && $past(mem_addr) == 8'hFF));

    assert_tau_placed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (depth == DEP_W'(TAU)));

    assert_idle_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE) |-> !word_ready);

endmodule

// File: tb/challenge_sampler_bench.sv
module challenge_sampler_bench;
    localparam int TAU    = 39;
    localparam int COEF_W = 23;
    localparam logic [COEF_W-1:0] Q = 23'd8380417;
    localparam int NB     = 1024;

    // stimulus table: {mode, seed, poke-start-while-busy}
    // mode 0: free bytes, 1: mostly 0xFF (rejections), 2: bytes 200..207 (repeats), 3: all 5
    localparam logic [34:0] CASES [6] = '{
        {2'd0, 32'h1234_5678, 1'b0},
        {2'd1, 32'h0BAD_F00D, 1'b0},
        {2'd2, 32'h0000_0042, 1'b1},
        {2'd3, 32'h0000_0001, 1'b0},
        {2'd0, 32'hDEAD_BEEF, 1'b1},
        {2'd2, 32'h7777_0001, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              done;
    logic              word_valid = 1'b0;
    logic              word_ready;
    logic [31:0]       word_data = '0;
    logic              mem_we;
    logic [7:0]        mem_addr;
    logic [COEF_W-1:0] mem_data;

    int n_chk = 0;
    int n_bad = 0;

    challenge_sampler #(.TAU(TAU), .WORD_W(32), .COEF_W(COEF_W), .Q(Q)) u_challenge_sampler (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    logic [7:0]        bytes [NB];
    logic [COEF_W-1:0] expv  [256];
    logic [COEF_W-1:0] got   [256];

    task automatic build(input logic [1:0] mode, input logic [31:0] seed);
        logic [31:0] r;
        int c [256];
        int pos;
        logic [63:0] sg;
        r = seed;
        for (int b = 0; b < NB; b++) begin
            r = r * 32'd1103515245 + 32'd12345;
            case (mode)
                2'd0: bytes[b] = r[23:16];
                2'd1: bytes[b] = (r[17:16] == 2'd0) ? r[31:24] : 8'hFF;
                2'd2: bytes[b] = 8'd200 + 8'(r[18:16]);
                default: bytes[b] = 8'd5;
            endcase
            if (b < 8) bytes[b] = r[31:24];
        end
        // array model of the shuffle
        for (int a = 0; a < 256; a++) c[a] = 0;
        for (int b = 0; b < 8; b++) sg[b*8 +: 8] = bytes[b];
        pos = 8;
        for (int i = 256 - TAU; i < 256; i++) begin
            int jj;
            jj = int'(bytes[pos]); pos++;
            while (jj > i) begin jj = int'(bytes[pos]); pos++; end
            c[i]  = c[jj];
            c[jj] = sg[i - (256 - TAU)] ? -1 : 1;
        end
        for (int a = 0; a < 256; a++)
            expv[a] = (c[a] == 0) ? '0 : (c[a] == 1) ? COEF_W'(1) : Q - COEF_W'(1);
    endtask

    task automatic run_case(input int idx, input logic [1:0] mode,
                            input logic [31:0] seed, input bit poke);
        int widx, cyc, nwr, last_we, nz;
        bit got_done, rdy;
        build(mode, seed);
        widx = 0; cyc = 0; nwr = 0; last_we = -10; got_done = 0; rdy = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!got_done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (mem_we) begin
                chk(mem_addr == 8'(nwr), "R5", "write address order", mem_addr, nwr);
                got[mem_addr] = mem_data;
                nwr++;
                last_we = cyc;
            end
            if (done) begin
                got_done = 1;
                chk(last_we == cyc - 1, "R6", "done one cycle after last write", last_we, cyc - 1);
                chk(nwr == 256, "R5", "number of writes", nwr, 256);
            end
            if (word_valid && rdy) widx++;
            // R7: a start pulse in mid-run must be ignored
            start      = (poke && cyc == 60) ? 1'b1 : 1'b0;
            word_data  = {bytes[4*widx+3], bytes[4*widx+2], bytes[4*widx+1], bytes[4*widx]};
            word_valid = 1'b1;
            rdy        = word_ready;
        end
        word_valid = 1'b0;
        start      = 1'b0;
        if (!got_done) chk(1'b0, "R6", "watchdog: done never seen", cyc, idx);
        nz = 0;
        for (int a = 0; a < 256; a++) begin
            if (got[a] != '0) nz++;
            // R2 R3 R4 R8: coefficient equals the array model
            chk(got[a] == expv[a], "R4", $sformatf("case %0d coef %0d", idx, a), got[a], expv[a]);
        end
        chk(nz == TAU, "R6", "nonzero count", nz, TAU);
        @(negedge clk);
        chk(!word_ready, "R7", "ready low after run", word_ready, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        chk(mem_we == 1'b0, "R1", "mem_we in reset", mem_we, 0);
        chk(word_ready == 1'b0, "R1", "word_ready in reset", word_ready, 0);
        rst_n = 1'b1;
        // R7: idle block does not take words
        word_valid = 1'b1;
        word_data  = 32'hFFFF_FFFF;
        repeat (4) begin
            @(negedge clk);
            chk(word_ready == 1'b0, "R7", "word_ready while idle", word_ready, 0);
            chk(mem_we == 1'b0, "R7", "no write while idle", mem_we, 0);
        end
        word_valid = 1'b0;
        foreach (CASES[n]) begin
            run_case(n, CASES[n][34:33], CASES[n][32:1], CASES[n][0]);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R6 global watchdog: actual %0d expected %0d", 190000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule